// File: doc/BRIEF.md
# Accelerometer Zero-g Offset Calibration and Compensation

This block learns the resting bias of a three-axis acceleration stream and then removes it from later samples. Software holds the sensor still with the z axis pointing along gravity and pulses a start input. The block then sums a set number of valid samples on each axis. It subtracts the ideal one-g reading (512 LSB for each sample) from the z sum. Each result is turned into a signed 8-bit correction code: the mean bias is negated, scaled down by four and rounded. The codes are held in registers, and every later sample has four times its axis code added to it before it leaves the block.

Samples are passed through all the time, including while a calibration is running. Until the new codes are loaded, they are corrected with the codes that were in force before. A one-cycle done pulse marks the cycle in which the new codes first appear.

Top module: `ofs_cal_top`

## Requirements
- R1: After reset the three codes read 0, `cal_done` is low and `out_vld` is low.
- R2: A sample accepted on `smp_vld` appears on `out_x/y/z` one cycle later, with `out_vld` high, as sample + 4 × code of its axis.
- R3: The compensated result saturates to the 13-bit signed range -4096 to +4095 and never wraps.
- R4: The x and y codes are −round(S / (4·N)), where S is the axis sum and N is the sample count. For example, single samples of +10 and −13 give codes −3 and +3.
- R5: The z code is −round((S − 512·N) / (4·N)). For example, a single z sample of 521 gives a code of −2.
- R6: The number of samples averaged is taken from `cal_len` when `cal_start` is seen. A setting of 0 is treated as 1. Only cycles with `smp_vld` high count, and idle cycles between samples are allowed.
- R7: Codes saturate to the range −128 to +127.
- R8: `cal_done` is a single-cycle pulse. The codes change only in the cycle where `cal_done` is high.
- R9: A `cal_start` pulse while a calibration is running is ignored. The sums and the count in progress carry on.
- R10: Samples that arrive during a calibration, including the samples being averaged, are compensated with the codes that were in force before that calibration.
- R11: Rounding on an exact half goes away from zero. A mean bias of +6 gives code −2, and a mean bias of −2 gives code +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_x | input | 13 | Signed x sample |
| smp_y | input | 13 | Signed y sample |
| smp_z | input | 13 | Signed z sample |
| cal_start | input | 1 | Begin a calibration run |
| cal_len | input | 8 | Number of samples to average (0 treated as 1) |
| out_vld | output | 1 | Compensated sample valid |
| out_x | output | 13 | Compensated x |
| out_y | output | 13 | Compensated y |
| out_z | output | 13 | Compensated z |
| code_x | output | 8 | Signed x correction code |
| code_y | output | 8 | Signed y correction code |
| code_z | output | 8 | Signed z correction code |
| cal_done | output | 1 | Codes loaded this cycle |

## Verification
The bench builds the block with its default parameters: 13-bit samples, an 8-bit count field and 8-bit codes. With these widths, full-scale samples drive the codes to both saturation limits, and those saturated codes then push the compensated output against both 13-bit rails. The 8-bit count makes the single-sample case, the zero setting and multi-sample runs with gaps all short enough to cover. Exact half cases of both signs are chosen so that the rounding direction shows up in the code.

// File: rtl/ofs_cal_pkg.sv
// Shared types for the offset calibration unit.
package ofs_cal_pkg;
    typedef enum logic [1:0] {CS_IDLE, CS_ACC, CS_DIV} cal_st_e;
endpackage

// File: rtl/ofs_cal_ctrl.sv
// Calibration sequencer: latches the sample count, counts valid samples,
// launches the per-axis dividers and reports completion.
// Assumes all axis dividers finish in the same cycle.
module ofs_cal_ctrl
    import ofs_cal_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic             cal_start,
    input  logic [CNT_W-1:0] cal_len,
    input  logic             all_fin,
    output logic             acc_clr,
    output logic             acc_en,
    output logic             div_go,
    output logic [CNT_W-1:0] n_lat,
    output logic             cal_done
);
    cal_st_e          st;
    logic [CNT_W-1:0] cnt;

    assign acc_clr  = (st == CS_IDLE) && cal_start;
    assign acc_en   = (st == CS_ACC) && smp_vld;
    assign cal_done = all_fin;

    // Sequencer state, sample counter and divider launch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= CS_IDLE;
            cnt    <= '0;
            n_lat  <= CNT_W'(1);
            div_go <= 1'b0;
        end else begin
            div_go <= 1'b0;
            case (st)
                CS_IDLE: if (cal_start) begin
                    n_lat <= (cal_len == '0) ? CNT_W'(1) : cal_len;
                    cnt   <= '0;
                    st    <= CS_ACC;
                end
                CS_ACC: if (smp_vld) begin
                    if (cnt == n_lat - CNT_W'(1)) begin
                        st     <= CS_DIV;
                        div_go <= 1'b1;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                CS_DIV: if (all_fin) st <= CS_IDLE;
                default: st <= CS_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_done); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CS_ACC) && cal_start && !smp_vld |=> (st == CS_ACC)); // R9
endmodule

// File: rtl/ofs_cal_axis.sv
// One axis: accumulates samples, then forms the rounded, negated,
// quarter-scaled and saturated correction code with a serial divider.
// Assumes n is nonzero and stable from div_go until fin.
module ofs_cal_axis #(
    parameter int DATA_W = 13,
    parameter int CNT_W  = 8,
    parameter int CODE_W = 8,
    parameter int ONE_G  = 512,
    parameter bit SUB_G  = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_clr,
    input  logic                     acc_en,
    input  logic signed [DATA_W-1:0] smp,
    input  logic                     div_go,
    input  logic [CNT_W-1:0]         n,
    output logic signed [CODE_W-1:0] code,
    output logic                     fin
);
    localparam int SUM_W   = DATA_W + CNT_W;
    localparam int NUM_W   = SUM_W + 2;
    localparam int DEN_W   = CNT_W + 2;
    localparam int IT_W    = $clog2(NUM_W + 1);
    localparam int POS_MAX = 2**(CODE_W-1) - 1;
    localparam int NEG_MAG = 2**(CODE_W-1);

    logic signed [SUM_W-1:0]  acc;
    logic signed [NUM_W-1:0]  num_c;
    logic [NUM_W-1:0]         bias_c, mag_c;
    logic [DEN_W-1:0]         rem, den, rem_dif;
    logic [DEN_W:0]           rem_sh;
    logic [NUM_W-1:0]         quo, quo_nx;
    logic                     ge, neg_q, busy;
    logic [IT_W-1:0]          it;
    logic signed [CODE_W-1:0] code_c;

    // Running sum of the samples taken during a calibration.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc <= '0;
        else if (acc_clr) acc <= '0;
        else if (acc_en)  acc <= acc + SUM_W'(smp);
    end

    // Numerator magnitude with the half-divisor added for rounding.
    always_comb begin
        bias_c = SUB_G ? (NUM_W'(ONE_G) * NUM_W'(n)) : '0;
        num_c  = $signed({{(NUM_W-SUM_W){acc[SUM_W-1]}}, acc}) - $signed(bias_c);
        mag_c  = (num_c[NUM_W-1] ? NUM_W'(-num_c) : NUM_W'(num_c)) + NUM_W'({n, 1'b0});
    end

    // One restoring division step and code saturation.
    always_comb begin
        rem_sh  = {rem, quo[NUM_W-1]};
        ge      = rem_sh >= {1'b0, den};
        rem_dif = rem_sh[DEN_W-1:0] - den;
        quo_nx  = {quo[NUM_W-2:0], ge};
        if (neg_q)
            code_c = (quo_nx > NUM_W'(POS_MAX)) ? CODE_W'(POS_MAX) : quo_nx[CODE_W-1:0];
        else if (quo_nx >= NUM_W'(NEG_MAG))
            code_c = {1'b1, {(CODE_W-1){1'b0}}};
        else
            code_c = (~quo_nx[CODE_W-1:0]) + 1'b1;
    end

    // Divider iteration and code register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0; quo <= '0; den <= '0; neg_q <= 1'b0;
            busy <= 1'b0; it <= '0; code <= '0; fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (div_go) begin
                rem   <= '0;
                quo   <= mag_c;
                den   <= {n, 2'b00};
                neg_q <= num_c[NUM_W-1];
                busy  <= 1'b1;
                it    <= IT_W'(NUM_W);
            end else if (busy) begin
                rem <= ge ? rem_dif : rem_sh[DEN_W-1:0];
                quo <= quo_nx;
                it  <= it - IT_W'(1);
                if (it == IT_W'(1)) begin
                    busy <= 1'b0;
                    code <= code_c;
                    fin  <= 1'b1;
                end
            end
        end
    end

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code) |-> fin); // R8
    AST_CODE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        fin && !neg_q |-> (code[CODE_W-1] || code == '0)); // R4
endmodule

// File: rtl/ofs_cal_comp.sv
// Adds four times the correction code to a sample and clamps the result
// to the sample range; registered, updated only on valid samples.
module ofs_cal_comp #(
    parameter int DATA_W = 13,
    parameter int CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld,
    input  logic signed [DATA_W-1:0] smp,
    input  logic signed [CODE_W-1:0] code,
    output logic signed [DATA_W-1:0] out
);
    localparam int SW = DATA_W + 2;
    localparam logic signed [SW-1:0] HI = SW'(2**(DATA_W-1) - 1);
    localparam logic signed [SW-1:0] LO = -HI - SW'(1);

    logic signed [SW-1:0] sum_c;

    // Widened sum of sample and scaled code.
    always_comb begin
        sum_c = $signed({{2{smp[DATA_W-1]}}, smp})
              + $signed({{(SW-CODE_W-2){code[CODE_W-1]}}, code, 2'b00});
    end

    // Clamped output register.
    always_ff @(posedge clk) begin
        if (!rst_n)       out <= '0;
        else if (vld) begin
            if (sum_c > HI)      out <= HI[DATA_W-1:0];
            else if (sum_c < LO) out <= LO[DATA_W-1:0];
            else                 out <= sum_c[DATA_W-1:0];
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        vld && !smp[DATA_W-1] && !code[CODE_W-1] |=> !out[DATA_W-1]); // R3
endmodule

// File: rtl/ofs_cal_top.sv
// Offset calibration and compensation unit: three axis engines, a
// sequencer and three compensation paths. z axis removes one g.
module ofs_cal_top #(
    parameter int DATA_W = 13,
    parameter int CNT_W  = 8,
    parameter int CODE_W = 8,
    parameter int ONE_G  = 512
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_vld,
    input  logic signed [DATA_W-1:0] smp_x,
    input  logic signed [DATA_W-1:0] smp_y,
    input  logic signed [DATA_W-1:0] smp_z,
    input  logic                     cal_start,
    input  logic [CNT_W-1:0]         cal_len,
    output logic                     out_vld,
    output logic signed [DATA_W-1:0] out_x,
    output logic signed [DATA_W-1:0] out_y,
    output logic signed [DATA_W-1:0] out_z,
    output logic signed [CODE_W-1:0] code_x,
    output logic signed [CODE_W-1:0] code_y,
    output logic signed [CODE_W-1:0] code_z,
    output logic                     cal_done
);
    localparam int AXES = 3;

    logic signed [DATA_W-1:0] smp_a  [AXES];
    logic signed [DATA_W-1:0] out_a  [AXES];
    logic signed [CODE_W-1:0] code_a [AXES];
    logic [AXES-1:0]          fin_a;
    logic                     acc_clr, acc_en, div_go;
    logic [CNT_W-1:0]         n_lat;

    assign smp_a[0] = smp_x;
    assign smp_a[1] = smp_y;
    assign smp_a[2] = smp_z;
    assign out_x  = out_a[0];
    assign out_y  = out_a[1];
    assign out_z  = out_a[2];
    assign code_x = code_a[0];
    assign code_y = code_a[1];
    assign code_z = code_a[2];

    ofs_cal_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .cal_start(cal_start),
        .cal_len(cal_len), .all_fin(&fin_a), .acc_clr(acc_clr),
        .acc_en(acc_en), .div_go(div_go), .n_lat(n_lat), .cal_done(cal_done)
    );

    for (genvar i = 0; i < AXES; i++) begin : g_axis
        ofs_cal_axis #(
            .DATA_W(DATA_W), .CNT_W(CNT_W), .CODE_W(CODE_W),
            .ONE_G(ONE_G), .SUB_G(i == AXES - 1)
        ) u_axis (
            .clk(clk), .rst_n(rst_n), .acc_clr(acc_clr), .acc_en(acc_en),
            .smp(smp_a[i]), .div_go(div_go), .n(n_lat),
            .code(code_a[i]), .fin(fin_a[i])
        );
        ofs_cal_comp #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_comp (
            .clk(clk), .rst_n(rst_n), .vld(smp_vld), .smp(smp_a[i]),
            .code(code_a[i]), .out(out_a[i])
        );
    end

    // Output valid follows the sample strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= smp_vld;
    end

    AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> out_vld); // R2
    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> !out_vld); // R2
endmodule

// File: tb/sim_ofs_cal_top.sv
module sim_ofs_cal_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic signed [12:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic cal_start = 1'b0;
    logic [7:0] cal_len = '0;
    logic out_vld, cal_done;
    logic signed [12:0] out_x, out_y, out_z;
    logic signed [7:0] code_x, code_y, code_z;

    typedef struct { int x; int y; int z; } exp_t;
    exp_t sb[$];
    int nchk = 0, nfail = 0;
    int mcx = 0, mcy = 0, mcz = 0;
    int xv[4], yv[4], zv[4];
    bit ended = 0;

    always #4 clk = ~clk;

    ofs_cal_top u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_x(smp_x),
        .smp_y(smp_y), .smp_z(smp_z), .cal_start(cal_start), .cal_len(cal_len),
        .out_vld(out_vld), .out_x(out_x), .out_y(out_y), .out_z(out_z),
        .code_x(code_x), .code_y(code_y), .code_z(code_z), .cal_done(cal_done)
    );

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int clamp(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    // Expected code from the requirement formulas (R4, R5, R7, R11).
    function automatic int ecode(int s, int n, bit zax);
        int num, a, mag;
        num = s - (zax ? 512 * n : 0);
        a   = (num < 0) ? -num : num;
        mag = (a + 2 * n) / (4 * n);
        if (num >= 0) return (mag > 128) ? -128 : -mag;
        return (mag > 127) ? 127 : mag;
    endfunction

    // Driver: one sample, expected result pushed to the scoreboard.
    task automatic send(int x, int y, int z);
        exp_t e;
        e.x = clamp(x + 4 * mcx, -4096, 4095);
        e.y = clamp(y + 4 * mcy, -4096, 4095);
        e.z = clamp(z + 4 * mcz, -4096, 4095);
        sb.push_back(e);
        smp_vld = 1'b1;
        smp_x = 13'(x); smp_y = 13'(y); smp_z = 13'(z);
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    // Monitor: compare every compensated sample (R2, R3, R10).
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (sb.size() == 0) chk("R2 unexpected out", 1, 0);
            else begin
                exp_t e;
                e = sb.pop_front();
                chk("R2/R10 out_x", int'(out_x), e.x);
                chk("R2/R10 out_y", int'(out_y), e.y);
                chk("R2/R10 out_z", int'(out_z), e.z);
            end
        end
    end

    // Calibration run of ns samples from xv/yv/zv.
    task automatic cal(int len, int ns, bit gaps, bit restart, string tag);
        int sx = 0, sy = 0, sz = 0, n, ex, ey, ez;
        bit seen = 0;
        n = (len == 0) ? 1 : len;
        cal_len = 8'(len);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        for (int i = 0; i < ns; i++) begin
            if (gaps) repeat (2) @(negedge clk);
            if (restart && i == 2) cal_start = 1'b1;
            sx += xv[i]; sy += yv[i]; sz += zv[i];
            send(xv[i], yv[i], zv[i]);
            cal_start = 1'b0;
        end
        chk({tag, " R8 code held before done"}, int'(code_x), mcx);
        ex = ecode(sx, n, 0); ey = ecode(sy, n, 0); ez = ecode(sz, n, 1);
        for (int k = 0; k < 100 && !seen; k++) begin
            @(negedge clk);
            if (cal_done) seen = 1;
        end
        chk({tag, " R8 done seen"}, int'(seen), 1);
        chk({tag, " code_x"}, int'(code_x), ex);
        chk({tag, " code_y"}, int'(code_y), ey);
        chk({tag, " R5 code_z"}, int'(code_z), ez);
        mcx = ex; mcy = ey; mcz = ez;
        @(negedge clk);
        chk({tag, " R8 done one cycle"}, int'(cal_done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset code_x", int'(code_x), 0);
        chk("R1 reset code_z", int'(code_z), 0);
        chk("R1 reset done", int'(cal_done), 0);
        chk("R1 reset out_vld", int'(out_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 passthrough with zero codes
        send(100, -200, 4095);
        send(-4096, 0, 7);
        // R4 R5 examples, single sample
        xv = '{10, 0, 0, 0}; yv = '{-13, 0, 0, 0}; zv = '{521, 0, 0, 0};
        cal(1, 1, 0, 0, "R4 example");
        send(100, -50, 0);
        // R6 R9 R11 R10: four samples, gaps, stray start mid-run
        xv = '{6, 6, 6, 6}; yv = '{-6, -6, -6, -6}; zv = '{100, 520, 500, 510};
        cal(4, 4, 1, 1, "R6 R9 R11 multi");
        // R6 zero setting treated as one; R11 negative half
        xv = '{-2, 0, 0, 0}; yv = '{2, 0, 0, 0}; zv = '{512, 0, 0, 0};
        cal(0, 1, 0, 0, "R6 R11 len0");
        // R7 code saturation
        xv = '{4000, 4000, 0, 0}; yv = '{-4000, -4000, 0, 0}; zv = '{-4096, -4096, 0, 0};
        cal(2, 2, 0, 0, "R7 sat");
        // R3 output saturation at both rails
        send(-4096, 4095, 0);
        send(4095, -4096, -4000);
        repeat (3) @(negedge clk);
        chk("R2 scoreboard drained", sb.size(), 0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset clears code_y", int'(code_y), 0);
        chk("R1 reset clears code_x", int'(code_x), 0);
        chk("R1 reset out_vld", int'(out_vld), 0);
        ended = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            nchk++; nfail++;
            $display("FAIL all watchdog act=running exp=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule